// File: doc/BRIEF.md
# Chip-Link Down Containment Controller

This block sits beside the upstream end of a chip-to-chip link and watches its data-link-up status. It also keeps a record of every downstream non-posted request that has been sent and still awaits a completion. A link that has never come up may drop and recover freely while training goes on. A link that loses data-link-up after it has been up is treated as a fatal, unrecoverable event. From then on the block withholds permission to retrain, leaving the system hung rather than risking corrupted data. It marks every outstanding request tag as dead, discards each completion that arrives later, and raises one system-error pulse attributed to device number 0.

Requests that already crossed the link before the drop are not recalled: the downstream side may finish them as usual, and only their completions are held back. The system-error pulse is the only error report the block produces. The fatal condition stays set until reset.

Top module: `linkdown_guard`

## Requirements
- R1: After reset, `train_en_o` is 1, `fatal_o` is 0, `serr_o` is 0, `pend_cnt_o` is 0, and neither `cpl_fwd_o` nor `cpl_drop_o` is set.
- R2: While the link has never reported up since reset, a low `link_up_i` never sets `fatal_o` or `serr_o`, and `train_en_o` stays 1.
- R3: If `link_up_i` is low in a cycle after the link has been up, `fatal_o` is 1 and `train_en_o` is 0 from the next cycle on. Both stay that way whatever `link_up_i` does, until reset.
- R4: `serr_o` is a single-cycle pulse in the cycle where `fatal_o` first reads 1, and it never pulses again before reset. `serr_dev_o` always reads 0.
- R5: A request (`req_valid_i` with `req_tag_i`) presented while the link is up and not fatal marks that tag outstanding. `pend_cnt_o` gives the number of outstanding tags one cycle later, and a repeated request for a tag already outstanding does not change the count.
- R6: A completion for an outstanding tag, presented while the link is up, gives `cpl_fwd_o`=1 with `cpl_fwd_tag_o` equal to its tag in the next cycle, and the tag is no longer outstanding.
- R7: A completion whose tag is not outstanding gives `cpl_drop_o`=1 and `cpl_fwd_o`=0 in the next cycle, and the outstanding count is unchanged.
- R8: On the fatal event all tags stop being outstanding (`pend_cnt_o`=0 next cycle). Every completion presented in the cycle of the drop or later is dropped and never forwarded.
- R9: A request presented while `link_up_i` is low, before the first link-up or after the fatal event, is ignored and does not change `pend_cnt_o`.
- R10: When a completion and a request carry the same tag in the same cycle, the completion is judged against the outstanding state before that cycle, and the tag is outstanding afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Data-link-up status of the chip link |
| req_valid_i | input | 1 | A downstream non-posted request is sent this cycle |
| req_tag_i | input | TAG_W | Tag of that request |
| cpl_valid_i | input | 1 | A completion arrives from downstream |
| cpl_tag_i | input | TAG_W | Tag of that completion |
| cpl_fwd_o | output | 1 | Completion passed upstream |
| cpl_fwd_tag_o | output | TAG_W | Tag of the forwarded completion |
| cpl_drop_o | output | 1 | Completion discarded |
| pend_cnt_o | output | TAG_W+1 | Number of outstanding tags |
| train_en_o | output | 1 | Link retraining permitted |
| fatal_o | output | 1 | Sticky fatal link-down state |
| serr_o | output | 1 | System-error pulse |
| serr_dev_o | output | 5 | Device number attributed to the system error (always 0) |

## Verification
The hardest situation to reach is the link dropping while many tags are outstanding, with a completion arriving in the very cycle the status falls. Completions that straddle the event must then be dropped rather than forwarded. The stimulus fills the whole tag space, drains it, and refills half of it plus two tags left over from the same-cycle request and completion tests. It then lowers `link_up_i` together with a completion for a live tag and sweeps completions over every tag afterwards. It also raises the link again, which must not clear the fatal state.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

  typedef enum logic [1:0] {
    LNK_TRAIN = 2'd0,
    LNK_UP    = 2'd1,
    LNK_DEAD  = 2'd2
  } lnk_state_e;

  localparam int         SERR_DEV_W = 5;
  localparam logic [4:0] SERR_DEV   = 5'd0;

  // Link was up and status is now low: the fatal event.
  function automatic logic fatal_edge(lnk_state_e s, logic up);
    return (s == LNK_UP) && !up;
  endfunction

  // Traffic is tracked and forwarded only on an up, healthy link.
  function automatic logic path_live(lnk_state_e s, logic up);
    return (s == LNK_UP) && up;
  endfunction

endpackage

// File: rtl/ldg_link_fsm.sv
module ldg_link_fsm
  import ldg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up_i,
  output lnk_state_e state_o,
  output logic       fatal_evt_o,
  output logic       live_o,
  output logic       serr_o
);

  lnk_state_e state_q, state_d;
  logic       serr_q;

  assign fatal_evt_o = fatal_edge(state_q, link_up_i);
  assign live_o      = path_live(state_q, link_up_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LNK_TRAIN: if (link_up_i) state_d = LNK_UP;
      LNK_UP:    if (fatal_evt_o) state_d = LNK_DEAD;
      LNK_DEAD:  state_d = LNK_DEAD;
      default:   state_d = LNK_DEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LNK_TRAIN;
      serr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      serr_q  <= fatal_evt_o;
    end
  end

  assign state_o = state_q;
  assign serr_o  = serr_q;

  assert_dead_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LNK_DEAD) |=> (state_q == LNK_DEAD))
    else $error("dead state left before reset");

  assert_no_fatal_pre_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LNK_TRAIN) |=> (state_q != LNK_DEAD))
    else $error("fatal reached without prior link-up");

  assert_serr_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LNK_DEAD) && $past(state_q == LNK_DEAD)) |-> !serr_q)
    else $error("system error repeated");

endmodule

// File: rtl/ldg_tag_table.sv
module ldg_tag_table #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live_i,
  input  logic             kill_i,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             cpl_valid_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  output logic             cpl_hit_o,
  output logic [TAG_W:0]   pend_cnt_o
);

  localparam int NTAG = 2 ** TAG_W;

  function automatic logic tag_is(logic [TAG_W-1:0] a, int unsigned t);
    return a == TAG_W'(t);
  endfunction

  function automatic logic [TAG_W:0] count_set(logic [NTAG-1:0] v);
    logic [TAG_W:0] c;
    c = '0;
    for (int i = 0; i < NTAG; i++) c = c + {{TAG_W{1'b0}}, v[i]};
    return c;
  endfunction

  logic [NTAG-1:0] pend_q;
  logic            req_acc;

  assign req_acc   = req_valid_i && live_i;
  assign cpl_hit_o = cpl_valid_i && live_i && pend_q[cpl_tag_i];

  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rst_n || kill_i)
        pend_q[t] <= 1'b0;
      else if (req_acc && tag_is(req_tag_i, t))
        pend_q[t] <= 1'b1;
      else if (cpl_hit_o && tag_is(cpl_tag_i, t))
        pend_q[t] <= 1'b0;
    end
  end

  assign pend_cnt_o = count_set(pend_q);

  assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (pend_cnt_o == '0))
    else $error("tags survive fatal event");

  assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_i && !kill_i) |=> $stable(pend_cnt_o))
    else $error("count moved while link not live");

endmodule

// File: rtl/ldg_cpl_path.sv
module ldg_cpl_path #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_valid_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  input  logic             cpl_hit_i,
  output logic             fwd_o,
  output logic [TAG_W-1:0] fwd_tag_o,
  output logic             drop_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_o     <= 1'b0;
      drop_o    <= 1'b0;
      fwd_tag_o <= '0;
    end else begin
      fwd_o  <= cpl_valid_i && cpl_hit_i;
      drop_o <= cpl_valid_i && !cpl_hit_i;
      if (cpl_valid_i) fwd_tag_o <= cpl_tag_i;
    end
  end

  assert_cpl_accounted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid_i |=> (fwd_o ^ drop_o))
    else $error("completion neither forwarded nor dropped");

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid_i |=> (!fwd_o && !drop_o))
    else $error("completion output without input");

endmodule

// File: rtl/linkdown_guard.sv
module linkdown_guard
  import ldg_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_up_i,
  input  logic                  req_valid_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic                  cpl_valid_i,
  input  logic [TAG_W-1:0]      cpl_tag_i,
  output logic                  cpl_fwd_o,
  output logic [TAG_W-1:0]      cpl_fwd_tag_o,
  output logic                  cpl_drop_o,
  output logic [TAG_W:0]        pend_cnt_o,
  output logic                  train_en_o,
  output logic                  fatal_o,
  output logic                  serr_o,
  output logic [SERR_DEV_W-1:0] serr_dev_o
);

  lnk_state_e lnk_state;
  logic       fatal_evt;
  logic       live;
  logic       cpl_hit;

  ldg_link_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_up_i   (link_up_i),
    .state_o     (lnk_state),
    .fatal_evt_o (fatal_evt),
    .live_o      (live),
    .serr_o      (serr_o)
  );

  ldg_tag_table #(.TAG_W(TAG_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_i      (live),
    .kill_i      (fatal_evt),
    .req_valid_i (req_valid_i),
    .req_tag_i   (req_tag_i),
    .cpl_valid_i (cpl_valid_i),
    .cpl_tag_i   (cpl_tag_i),
    .cpl_hit_o   (cpl_hit),
    .pend_cnt_o  (pend_cnt_o)
  );

  ldg_cpl_path #(.TAG_W(TAG_W)) u_cpl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpl_valid_i (cpl_valid_i),
    .cpl_tag_i   (cpl_tag_i),
    .cpl_hit_i   (cpl_hit),
    .fwd_o       (cpl_fwd_o),
    .fwd_tag_o   (cpl_fwd_tag_o),
    .drop_o      (cpl_drop_o)
  );

  assign fatal_o    = (lnk_state == LNK_DEAD);
  assign train_en_o = (lnk_state != LNK_DEAD);
  assign serr_dev_o = SERR_DEV;

  assert_no_fwd_when_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> !cpl_fwd_o)
    else $error("completion forwarded after fatal event");

  assert_serr_with_fatal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> (fatal_o && !train_en_o))
    else $error("system error without fatal state");

  assert_fatal_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_o) |-> (pend_cnt_o == '0))
    else $error("tags outstanding on entry to fatal state");

endmodule

// File: tb/tb_linkdown_guard.sv
module tb_linkdown_guard;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W      = 4;
  localparam int NTAG       = 1 << TAG_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             link_up;
  logic             req_valid;
  logic [TAG_W-1:0] req_tag;
  logic             cpl_valid;
  logic [TAG_W-1:0] cpl_tag;
  logic             cpl_fwd;
  logic [TAG_W-1:0] cpl_fwd_tag;
  logic             cpl_drop;
  logic [TAG_W:0]   pend_cnt;
  logic             train_en;
  logic             fatal;
  logic             serr;
  logic [4:0]       serr_dev;

  int errors = 0;
  int checks = 0;
  int exp_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  linkdown_guard #(.TAG_W(TAG_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_up_i     (link_up),
    .req_valid_i   (req_valid),
    .req_tag_i     (req_tag),
    .cpl_valid_i   (cpl_valid),
    .cpl_tag_i     (cpl_tag),
    .cpl_fwd_o     (cpl_fwd),
    .cpl_fwd_tag_o (cpl_fwd_tag),
    .cpl_drop_o    (cpl_drop),
    .pend_cnt_o    (pend_cnt),
    .train_en_o    (train_en),
    .fatal_o       (fatal),
    .serr_o        (serr),
    .serr_dev_o    (serr_dev)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one cycle of inputs at the falling edge; sample just after the rising edge.
  task automatic step(input logic up, input logic rv, input int rt,
                      input logic cv, input int ct);
    @(negedge clk);
    link_up   = up;
    req_valid = rv;
    req_tag   = TAG_W'(rt);
    cpl_valid = cv;
    cpl_tag   = TAG_W'(ct);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; link_up = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
    req_tag = '0; cpl_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R1: reset state
    chk("R1 train_en", int'(train_en), 1);
    chk("R1 fatal", int'(fatal), 0);
    chk("R1 serr", int'(serr), 0);
    chk("R1 pend_cnt", int'(pend_cnt), 0);
    chk("R1 fwd", int'(cpl_fwd), 0);
    chk("R1 drop", int'(cpl_drop), 0);

    // R2 / R9: link low before first up; requests ignored, completions dropped
    for (int t = 0; t < 4; t++) begin
      step(1'b0, 1'b1, t, 1'b1, t + 4);
      chk("R9 pre-up request ignored", int'(pend_cnt), 0);
      chk("R2 no fatal before up", int'(fatal), 0);
      chk("R2 training allowed", int'(train_en), 1);
      chk("R2 no serr before up", int'(serr), 0);
      chk("R7 pre-up completion dropped", int'(cpl_drop), 1);
    end

    // Bring link up
    step(1'b1, 1'b0, 0, 1'b0, 0);
    chk("R2 up not fatal", int'(fatal), 0);

    // R5: fill every tag
    for (int t = 0; t < NTAG; t++) begin
      step(1'b1, 1'b1, t, 1'b0, 0);
      chk("R5 count grows", int'(pend_cnt), t + 1);
    end
    step(1'b1, 1'b1, 3, 1'b0, 0);
    chk("R5 duplicate request", int'(pend_cnt), NTAG);

    // R6: drain in reverse order
    for (int t = NTAG - 1; t >= 0; t--) begin
      step(1'b1, 1'b0, 0, 1'b1, t);
      chk("R6 forwarded", int'(cpl_fwd), 1);
      chk("R6 forwarded tag", int'(cpl_fwd_tag), t);
      chk("R6 not dropped", int'(cpl_drop), 0);
      chk("R6 count shrinks", int'(pend_cnt), t);
    end

    // R7: unknown tag
    step(1'b1, 1'b0, 0, 1'b1, 5);
    chk("R7 unknown dropped", int'(cpl_drop), 1);
    chk("R7 unknown not forwarded", int'(cpl_fwd), 0);
    chk("R7 count unchanged", int'(pend_cnt), 0);

    // R10: same-tag request and completion in one cycle
    step(1'b1, 1'b1, 7, 1'b0, 0);
    chk("R5 tag 7 pending", int'(pend_cnt), 1);
    step(1'b1, 1'b1, 7, 1'b1, 7);
    chk("R10 outstanding tag forwarded", int'(cpl_fwd), 1);
    chk("R10 tag stays outstanding", int'(pend_cnt), 1);
    step(1'b1, 1'b1, 9, 1'b1, 9);
    chk("R10 new tag completion dropped", int'(cpl_drop), 1);
    chk("R10 new tag outstanding", int'(pend_cnt), 2);

    // Refill even tags (7 and 9 already outstanding)
    exp_cnt = 2;
    for (int t = 0; t < NTAG; t += 2) begin
      step(1'b1, 1'b1, t, 1'b0, 0);
      exp_cnt++;
    end
    chk("R5 refill count", int'(pend_cnt), exp_cnt);

    // R3/R4/R8: link drops with a completion for a live tag in the same cycle
    step(1'b0, 1'b1, 1, 1'b1, 0);
    chk("R3 fatal set", int'(fatal), 1);
    chk("R3 training blocked", int'(train_en), 0);
    chk("R4 serr pulse", int'(serr), 1);
    chk("R4 serr device", int'(serr_dev), 0);
    chk("R8 tags cleared", int'(pend_cnt), 0);
    chk("R8 drop-cycle completion dropped", int'(cpl_drop), 1);
    chk("R8 drop-cycle completion not forwarded", int'(cpl_fwd), 0);

    step(1'b0, 1'b0, 0, 1'b0, 0);
    chk("R4 serr single cycle", int'(serr), 0);
    chk("R3 fatal sticky", int'(fatal), 1);

    step(1'b1, 1'b1, 1, 1'b0, 0);
    chk("R3 fatal survives link up", int'(fatal), 1);
    chk("R3 training still blocked", int'(train_en), 0);
    chk("R9 post-fatal request ignored", int'(pend_cnt), 0);

    for (int t = 0; t < NTAG; t++) begin
      step(1'b1, 1'b1, t, 1'b1, t);
      chk("R8 late completion dropped", int'(cpl_drop), 1);
      chk("R8 late completion not forwarded", int'(cpl_fwd), 0);
      chk("R4 no repeat serr", int'(serr), 0);
      chk("R9 count stays zero", int'(pend_cnt), 0);
    end
    step(1'b0, 1'b0, 0, 1'b0, 0);
    chk("R3 still fatal", int'(fatal), 1);

    // R3: only reset clears the fatal state
    do_reset();
    chk("R3 reset clears fatal", int'(fatal), 0);
    chk("R3 reset restores training", int'(train_en), 1);
    chk("R1 count after reset", int'(pend_cnt), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule